// File: doc/BRIEF.md
# Interrupt Vector Message Table with Pending Bits

This block keeps, for a configurable number of interrupt vectors, the message that each vector sends: a 64-bit target address and a 32-bit data word, plus a 32-bit control word whose bit 0 masks the vector. Beside the table it keeps one pending bit per vector. Software reaches both through a byte-offset access port that moves 4 or 8 bytes per access, little-endian. The pending bits can be read but not written.

An event input names a vector. When the function is enabled, the function mask is clear and the vector itself is unmasked, the event produces a message right away. Otherwise the event only records a pending bit. A later table write that unmasks a vector whose pending bit is set sends the deferred message at once and clears the bit. Messages leave through a small in-order queue with a valid/ready handshake. The function-level enable and mask arrive as plain inputs.

Top module: `msix_vector_unit`

## Requirements
- R1: After reset every entry reads address low 0, address high 0, data 0 and control 0x00000001, and all pending bits read 0.
- R2: A table entry is 16 bytes at byte offset index*16. Within it, dword 0x0 is address low, 0x4 address high, 0x8 data and 0xC control. A read returns its value on rd_data one cycle after the request, with rd_valid high. A 4-byte value sits in bits 31:0, and bits 63:32 are zero.
- R3: An 8-byte access at entry offset 0x0 carries {address high, address low}, and at 0x8 carries {control, data}. Any other entry offset, or a 4-byte offset that is not a multiple of 4, reads 0 and is ignored on write.
- R4: An access whose entry index is at or above NUM_VEC reads all-ones (0x00000000FFFFFFFF for 4 bytes, all 64 bits for 8 bytes), and a write there changes nothing.
- R5: The pending array (acc_pend=1) packs vectors 64 per 8-byte word, with vector v at bit v%64 of word v/64, in NUM_VEC/64+1 words. A 4-byte read at word offset 0 returns bits 31:0 and at offset 4 returns bits 63:32. An 8-byte read at offset 0 returns the word. Other offsets read 0. A word beyond the last reads all-ones as in R4.
- R6: Writes to the pending array have no effect.
- R7: An event on an in-range vector, with fn_enable=1, fn_mask=0 and that vector's control bit 0 clear, queues a message with address {high, low} and the entry's data. The message is valid in the cycle after the event, and the pending bit is left unchanged.
- R8: An event that does not meet the conditions of R7 sets the vector's pending bit and produces no message.
- R9: A table write under fn_enable=1 and fn_mask=0 that changes a vector's control bit 0 from 1 to 0 while its pending bit is set queues that vector's message, using the entry's values after the write, and clears the pending bit. No other write produces a message.
- R10: When a write releases a vector as in R9 and an event on the same vector arrives in the same cycle, exactly one message is produced and the pending bit ends set.
- R11: Messages leave in the order they were queued, each held stable on msg_addr/msg_data while msg_valid is high and msg_ready is low. An event under R7 that finds the FIFO_DEPTH-entry queue full sets its pending bit instead.
- R12: An event whose vector index is at or above NUM_VEC is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_pend | input | 1 | 1 = pending array, 0 = vector table |
| acc_wide | input | 1 | 1 = 8-byte access, 0 = 4-byte |
| acc_offset | input | OFF_W | Byte offset within the selected space |
| acc_wdata | input | 64 | Write data, little-endian, 4-byte data in bits 31:0 |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| fn_enable | input | 1 | Function-level message enable |
| fn_mask | input | 1 | Function-level mask |
| evt_valid | input | 1 | Interrupt event strobe |
| evt_vec | input | VEC_W | Vector index of the event |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message data |

## Verification
The bench works on a 16-vector configuration. It sweeps every entry and every dword, both with 4-byte and with 8-byte accesses, using values derived arithmetically from the vector index, so that a swapped field or a wrong entry decode shows up as a mismatch. Events are swept over all vectors three times: with the function disabled, which separates deferral from delivery; through a per-vector unmask, which tests the release path and its pending clear; and with everything open, which tests direct delivery. Directed cases then separate the corner rules: a rewrite that leaves the mask clear, an unmask under the function mask, a release that carries new data, the same-cycle release plus event, a queue overflow under back-pressure, and out-of-range indices and offsets.

// File: rtl/msix_pkg.sv
package msix_pkg;

    // one outgoing message: 64-bit target address and 32-bit payload
    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    // dword slots inside a 16-byte entry (bits 3:2 of the byte offset)
    localparam logic [1:0] SLOT_ADDR_LO = 2'd0;
    localparam logic [1:0] SLOT_ADDR_HI = 2'd1;
    localparam logic [1:0] SLOT_DATA    = 2'd2;
    localparam logic [1:0] SLOT_CTRL    = 2'd3;

    localparam logic [31:0] CTRL_RESET  = 32'h0000_0001;

endpackage

// File: rtl/msix_acc_decode.sv
module msix_acc_decode #(
    parameter int NUM_VEC = 16,
    parameter int OFF_W   = 12,
    localparam int IDX_W  = $clog2(NUM_VEC)
) (
    input  logic [OFF_W-1:0] offset,
    input  logic             wide,
    output logic             tbl_ok,
    output logic             tbl_legal,
    output logic [IDX_W-1:0] tbl_idx,
    output logic [1:0]       slot,
    output logic             pw_ok,
    output logic             pw_legal,
    output logic             pw_hi,
    output logic [OFF_W-4:0] pw_idx
);
    localparam int PEND_WORDS = NUM_VEC / 64 + 1;

    logic [OFF_W-5:0] tbl_full;
    logic [3:0]       tsub;
    logic [2:0]       psub;

    always_comb begin
        tbl_full  = offset[OFF_W-1:4];
        tsub      = offset[3:0];
        psub      = offset[2:0];
        tbl_ok    = int'(tbl_full) < NUM_VEC;
        tbl_idx   = tbl_full[IDX_W-1:0];
        slot      = tsub[3:2];
        tbl_legal = wide ? (tsub == 4'h0 || tsub == 4'h8) : (tsub[1:0] == 2'b00);
        pw_idx    = offset[OFF_W-1:3];
        pw_ok     = int'(pw_idx) < PEND_WORDS;
        pw_legal  = wide ? (psub == 3'd0) : (psub == 3'd0 || psub == 3'd4);
        pw_hi     = psub[2];
    end
endmodule

// File: rtl/msix_msg_fifo.sv
module msix_msg_fifo
    import msix_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_a,
    input  msg_t msg_a,
    input  logic req_b,
    input  msg_t msg_b,
    output logic acc_a,
    output logic acc_b,
    input  logic out_ready,
    output logic out_valid,
    output msg_t out_msg
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t             st_d, st_q;
    msg_t             mem_d [DEPTH];
    msg_t             mem_q [DEPTH];
    logic [CNT_W-1:0] room;
    logic [PTR_W-1:0] wr_ptr;
    logic             pop;

    always_comb begin
        st_d      = st_q;
        mem_d     = mem_q;
        room      = CNT_W'(DEPTH) - st_q.cnt;
        out_valid = st_q.cnt != '0;
        out_msg   = mem_q[st_q.rd];
        pop       = out_valid && out_ready;
        acc_a     = req_a && room >= CNT_W'(1);
        acc_b     = req_b && room >= (acc_a ? CNT_W'(2) : CNT_W'(1));
        wr_ptr    = st_q.wr;
        if (acc_a) begin
            mem_d[wr_ptr] = msg_a;
            wr_ptr        = wr_ptr + 1'b1;
        end
        if (acc_b) begin
            mem_d[wr_ptr] = msg_b;
            wr_ptr        = wr_ptr + 1'b1;
        end
        st_d.wr = wr_ptr;
        if (pop) st_d.rd = st_q.rd + 1'b1;
        st_d.cnt = st_q.cnt + CNT_W'(acc_a) + CNT_W'(acc_b) - CNT_W'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/msix_vector_unit.sv
module msix_vector_unit
    import msix_pkg::*;
#(
    parameter int NUM_VEC    = 16,
    parameter int OFF_W      = 12,
    parameter int FIFO_DEPTH = 4,
    parameter int VEC_W      = $clog2(NUM_VEC) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_pend,
    input  logic             acc_wide,
    input  logic [OFF_W-1:0] acc_offset,
    input  logic [63:0]      acc_wdata,
    output logic             rd_valid,
    output logic [63:0]      rd_data,
    input  logic             fn_enable,
    input  logic             fn_mask,
    input  logic             evt_valid,
    input  logic [VEC_W-1:0] evt_vec,
    output logic             msg_valid,
    input  logic             msg_ready,
    output logic [63:0]      msg_addr,
    output logic [31:0]      msg_data
);
    localparam int IDX_W      = $clog2(NUM_VEC);
    localparam int PEND_WORDS = NUM_VEC / 64 + 1;
    localparam int PEND_BITS  = PEND_WORDS * 64;
    localparam logic [63:0] ONES4 = 64'h0000_0000_FFFF_FFFF;

    typedef struct packed {
        logic        rd_valid;
        logic [63:0] rd_data;
    } rd_t;

    rd_t                  rd_d, rd_q;
    logic [31:0]          lo_d [NUM_VEC];
    logic [31:0]          lo_q [NUM_VEC];
    logic [31:0]          hi_d [NUM_VEC];
    logic [31:0]          hi_q [NUM_VEC];
    logic [31:0]          dat_d [NUM_VEC];
    logic [31:0]          dat_q [NUM_VEC];
    logic [31:0]          ctl_d [NUM_VEC];
    logic [31:0]          ctl_q [NUM_VEC];
    logic [NUM_VEC-1:0]   pend_d, pend_q;
    logic [PEND_BITS-1:0] pend_pad;
    logic [63:0]          pend_word;

    logic             tbl_ok, tbl_legal, pw_ok, pw_legal, pw_hi;
    logic [IDX_W-1:0] tbl_idx, evt_idx;
    logic [1:0]       slot;
    logic [OFF_W-4:0] pw_idx;
    logic             wr_tbl, evt_ok, evt_live;
    logic             req_a, req_b, acc_a, acc_b;
    msg_t             msg_a, msg_b, out_msg;

    msix_acc_decode #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W)) u_dec (
        .offset(acc_offset), .wide(acc_wide),
        .tbl_ok(tbl_ok), .tbl_legal(tbl_legal), .tbl_idx(tbl_idx), .slot(slot),
        .pw_ok(pw_ok), .pw_legal(pw_legal), .pw_hi(pw_hi), .pw_idx(pw_idx)
    );

    // table, read path and message requests
    always_comb begin
        lo_d  = lo_q;
        hi_d  = hi_q;
        dat_d = dat_q;
        ctl_d = ctl_q;
        rd_d.rd_valid = acc_valid && !acc_write;
        rd_d.rd_data  = rd_q.rd_data;
        pend_pad  = PEND_BITS'(pend_q);
        pend_word = '0;
        for (int w = 0; w < PEND_WORDS; w++)
            if (int'(pw_idx) == w) pend_word = pend_pad[w*64 +: 64];

        if (acc_valid && !acc_write) begin
            if (acc_pend) begin
                if (!pw_ok)         rd_d.rd_data = acc_wide ? '1 : ONES4;
                else if (!pw_legal) rd_d.rd_data = '0;
                else if (acc_wide)  rd_d.rd_data = pend_word;
                else                rd_d.rd_data = {32'h0, pw_hi ? pend_word[63:32] : pend_word[31:0]};
            end else begin
                if (!tbl_ok)         rd_d.rd_data = acc_wide ? '1 : ONES4;
                else if (!tbl_legal) rd_d.rd_data = '0;
                else if (acc_wide)   rd_d.rd_data = slot[1] ? {ctl_q[tbl_idx], dat_q[tbl_idx]}
                                                            : {hi_q[tbl_idx], lo_q[tbl_idx]};
                else begin
                    case (slot)
                        SLOT_ADDR_LO: rd_d.rd_data = {32'h0, lo_q[tbl_idx]};
                        SLOT_ADDR_HI: rd_d.rd_data = {32'h0, hi_q[tbl_idx]};
                        SLOT_DATA:    rd_d.rd_data = {32'h0, dat_q[tbl_idx]};
                        default:      rd_d.rd_data = {32'h0, ctl_q[tbl_idx]};
                    endcase
                end
            end
        end

        wr_tbl = acc_valid && acc_write && !acc_pend && tbl_ok && tbl_legal;
        req_a  = 1'b0;
        msg_a  = '0;
        if (wr_tbl) begin
            if (acc_wide) begin
                if (slot[1]) begin
                    dat_d[tbl_idx] = acc_wdata[31:0];
                    ctl_d[tbl_idx] = acc_wdata[63:32];
                end else begin
                    lo_d[tbl_idx] = acc_wdata[31:0];
                    hi_d[tbl_idx] = acc_wdata[63:32];
                end
            end else begin
                case (slot)
                    SLOT_ADDR_LO: lo_d[tbl_idx]  = acc_wdata[31:0];
                    SLOT_ADDR_HI: hi_d[tbl_idx]  = acc_wdata[31:0];
                    SLOT_DATA:    dat_d[tbl_idx] = acc_wdata[31:0];
                    default:      ctl_d[tbl_idx] = acc_wdata[31:0];
                endcase
            end
            // release of a deferred message on a 1->0 mask transition
            req_a = fn_enable && !fn_mask && ctl_q[tbl_idx][0] && !ctl_d[tbl_idx][0]
                    && pend_q[tbl_idx];
            msg_a = '{addr: {hi_d[tbl_idx], lo_d[tbl_idx]}, data: dat_d[tbl_idx]};
        end

        evt_idx  = evt_vec[IDX_W-1:0];
        evt_ok   = evt_valid && int'(evt_vec) < NUM_VEC;
        evt_live = evt_ok && fn_enable && !fn_mask && !ctl_q[evt_idx][0];
        req_b    = evt_live;
        msg_b    = '{addr: {hi_q[evt_idx], lo_q[evt_idx]}, data: dat_q[evt_idx]};
    end

    // pending bits: release clears, a deferred event sets (set wins)
    always_comb begin
        pend_d = pend_q;
        if (acc_a) pend_d[tbl_idx] = 1'b0;
        if (evt_ok && !(evt_live && acc_b)) pend_d[evt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            pend_q <= '0;
            for (int i = 0; i < NUM_VEC; i++) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                dat_q[i] <= '0;
                ctl_q[i] <= CTRL_RESET;
            end
        end else begin
            rd_q   <= rd_d;
            pend_q <= pend_d;
            lo_q   <= lo_d;
            hi_q   <= hi_d;
            dat_q  <= dat_d;
            ctl_q  <= ctl_d;
        end
    end

    msix_msg_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .req_a(req_a), .msg_a(msg_a), .req_b(req_b), .msg_b(msg_b),
        .acc_a(acc_a), .acc_b(acc_b),
        .out_ready(msg_ready), .out_valid(msg_valid), .out_msg(out_msg)
    );

    assign rd_valid = rd_q.rd_valid;
    assign rd_data  = rd_q.rd_data;
    assign msg_addr = out_msg.addr;
    assign msg_data = out_msg.data;
endmodule

// File: rtl/msix_vector_unit_chk.sv
module msix_vector_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic        rd_valid,
    input logic        fn_enable,
    input logic        fn_mask,
    input logic        msg_valid,
    input logic        msg_ready,
    input logic [63:0] msg_addr,
    input logic [31:0] msg_data
);
    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11

    AST_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && !acc_write |=> rd_valid); // R2

    AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> !rd_valid); // R2

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && !fn_enable |=> !msg_valid); // R8

    AST_FNMASK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid && fn_mask |=> !msg_valid); // R8
endmodule

bind msix_vector_unit msix_vector_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .rd_valid(rd_valid), .fn_enable(fn_enable), .fn_mask(fn_mask),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msix_vector_unit_tb.sv
`timescale 1ns/1ps
module msix_vector_unit_tb_top;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_pend = 1'b0, acc_wide = 1'b0;
    logic [11:0] acc_offset = '0;
    logic [63:0] acc_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        fn_enable = 1'b0, fn_mask = 1'b0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_vec = '0;
    logic        msg_valid, msg_ready = 1'b0;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [15:0] pend_exp = '0;
    logic [63:0] got;

    always #10 clk = ~clk;

    msix_vector_unit #(.NUM_VEC(NV), .OFF_W(12), .FIFO_DEPTH(4), .VEC_W(5)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_pend(acc_pend), .acc_wide(acc_wide), .acc_offset(acc_offset),
        .acc_wdata(acc_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .fn_enable(fn_enable), .fn_mask(fn_mask), .evt_valid(evt_valid), .evt_vec(evt_vec),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    function automatic logic [31:0] lo_of(int i); return 32'h1000_0000 + 32'(i * 16); endfunction
    function automatic logic [31:0] hi_of(int i); return 32'hA000_0000 + 32'(i); endfunction
    function automatic logic [31:0] dt_of(int i); return 32'hD000_0000 + 32'(i); endfunction

    task automatic chk(logic [63:0] act, logic [63:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(bit pend, bit wide, int off, logic [63:0] wd);
        acc_valid = 1; acc_write = 1; acc_pend = pend; acc_wide = wide;
        acc_offset = 12'(off); acc_wdata = wd;
        @(posedge clk); @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic rd(bit pend, bit wide, int off, output logic [63:0] d);
        acc_valid = 1; acc_write = 0; acc_pend = pend; acc_wide = wide;
        acc_offset = 12'(off);
        @(posedge clk); @(negedge clk);
        acc_valid = 0;
        d = rd_data;
    endtask

    task automatic rd_chk(bit pend, bit wide, int off, logic [63:0] exp, string tag);
        logic [63:0] d;
        rd(pend, wide, off, d);
        chk(d, exp, tag);
    endtask

    task automatic pend_chk(string tag);
        rd_chk(1, 0, 0, {48'h0, pend_exp}, tag);
    endtask

    task automatic evt(int v);
        evt_valid = 1; evt_vec = 5'(v);
        @(posedge clk); @(negedge clk);
        evt_valid = 0;
    endtask

    task automatic take_msg(int v, logic [31:0] d, string tag);
        chk({63'h0, msg_valid}, 64'h1, {tag, " valid"});
        chk(msg_addr, {hi_of(v), lo_of(v)}, {tag, " addr"});
        chk({32'h0, msg_data}, {32'h0, d}, {tag, " data"});
        msg_ready = 1;
        @(posedge clk); @(negedge clk);
        msg_ready = 0;
    endtask

    task automatic no_msg(string tag);
        chk({63'h0, msg_valid}, 64'h0, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset contents
        for (int i = 0; i < NV; i++) begin
            rd_chk(0, 0, i*16 + 0,  64'h0, "R1 lo");
            rd_chk(0, 0, i*16 + 4,  64'h0, "R1 hi");
            rd_chk(0, 0, i*16 + 8,  64'h0, "R1 data");
            rd_chk(0, 0, i*16 + 12, 64'h1, "R1 ctrl");
        end
        rd_chk(1, 1, 0, 64'h0, "R1 pending");

        // R2/R3 write every entry, alternating access widths
        for (int i = 0; i < NV; i++) begin
            if (i % 2 == 0) begin
                wr(0, 0, i*16 + 0, {32'h0, lo_of(i)});
                wr(0, 0, i*16 + 4, {32'h0, hi_of(i)});
                wr(0, 0, i*16 + 8, {32'h0, dt_of(i)});
            end else begin
                wr(0, 1, i*16 + 0, {hi_of(i), lo_of(i)});
                wr(0, 1, i*16 + 8, {32'h1, dt_of(i)});
            end
        end
        for (int i = 0; i < NV; i++) begin
            rd_chk(0, 0, i*16 + 0, {32'h0, lo_of(i)}, "R2 lo");
            rd_chk(0, 0, i*16 + 4, {32'h0, hi_of(i)}, "R2 hi");
            rd_chk(0, 0, i*16 + 8, {32'h0, dt_of(i)}, "R2 data");
            rd_chk(0, 1, i*16 + 0, {hi_of(i), lo_of(i)}, "R3 wide addr");
            rd_chk(0, 1, i*16 + 8, {32'h1, dt_of(i)}, "R3 wide ctrl/data");
        end

        // R3 illegal offsets
        rd_chk(0, 0, 16 + 2, 64'h0, "R3 misaligned 4-byte read");
        rd_chk(0, 1, 16 + 4, 64'h0, "R3 8-byte at 0x4 read");
        wr(0, 1, 16 + 4, 64'h5555_5555_5555_5555);
        rd_chk(0, 1, 16, {hi_of(1), lo_of(1)}, "R3 8-byte at 0x4 write ignored");
        rd_chk(0, 1, 16 + 8, {32'h1, dt_of(1)}, "R3 8-byte at 0x4 write ignored ctrl");

        // R4 out-of-range entries
        rd_chk(0, 0, NV*16, 64'h0000_0000_FFFF_FFFF, "R4 4-byte beyond");
        rd_chk(0, 1, 200*16 + 8, 64'hFFFF_FFFF_FFFF_FFFF, "R4 8-byte beyond");
        wr(0, 0, NV*16, 64'h0000_0000_1234_5678);
        rd_chk(0, 0, 0, {32'h0, lo_of(0)}, "R4 write beyond discarded");

        // R5/R6 pending layout and read-only
        wr(1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd_chk(1, 1, 0, 64'h0, "R6 pending write ignored");
        rd_chk(1, 1, 8, 64'hFFFF_FFFF_FFFF_FFFF, "R5 word beyond");
        rd_chk(1, 0, 12, 64'h0000_0000_FFFF_FFFF, "R5 4-byte word beyond");
        rd_chk(1, 0, 2, 64'h0, "R5 illegal offset");

        // R8 events while disabled: defer to pending
        for (int i = 0; i < NV; i++) begin
            evt(i);
            pend_exp[i] = 1'b1;
            no_msg("R8 disabled event no message");
        end
        pend_chk("R8 pending low half");
        rd_chk(1, 0, 4, 64'h0, "R5 pending high half");
        rd_chk(1, 1, 0, {48'h0, pend_exp}, "R5 pending 8-byte");

        // R9 release each vector by unmasking
        fn_enable = 1;
        for (int i = 0; i < NV; i++) begin
            wr(0, 0, i*16 + 12, 64'h0);
            take_msg(i, dt_of(i), "R9 release");
            pend_exp[i] = 1'b0;
            no_msg("R9 single release");
        end
        pend_chk("R9 pending cleared");

        // R7 direct delivery
        for (int i = 0; i < NV; i++) begin
            evt(i);
            take_msg(i, dt_of(i), "R7 direct");
        end
        pend_chk("R7 pending unchanged");

        // R9 negatives and release with new data
        wr(0, 0, 5*16 + 12, 64'h0);
        no_msg("R9 rewrite of clear mask");
        fn_mask = 1;
        evt(5);
        pend_exp[5] = 1'b1;
        no_msg("R8 function-masked event");
        wr(0, 0, 5*16 + 12, 64'h1);
        wr(0, 0, 5*16 + 12, 64'h0);
        no_msg("R9 unmask under function mask");
        pend_chk("R9 pending kept under function mask");
        fn_mask = 0;
        wr(0, 0, 5*16 + 12, 64'h1);
        no_msg("R9 masking write");
        wr(0, 0, 5*16 + 12, 64'h0);
        take_msg(5, dt_of(5), "R9 release after function unmask");
        pend_exp[5] = 1'b0;
        wr(0, 0, 6*16 + 12, 64'h1);
        evt(6);
        pend_exp[6] = 1'b1;
        no_msg("R8 vector-masked event");
        wr(0, 1, 6*16 + 8, 64'h0000_0000_BEEF_0006);
        take_msg(6, 32'hBEEF_0006, "R9 release uses new data");
        pend_exp[6] = 1'b0;
        pend_chk("R9 pending after releases");

        // R10 release and event on the same vector in one cycle
        wr(0, 0, 3*16 + 12, 64'h1);
        evt(3);
        pend_exp[3] = 1'b1;
        acc_valid = 1; acc_write = 1; acc_pend = 0; acc_wide = 0;
        acc_offset = 12'(3*16 + 12); acc_wdata = 64'h0;
        evt_valid = 1; evt_vec = 5'd3;
        @(posedge clk); @(negedge clk);
        acc_valid = 0; acc_write = 0; evt_valid = 0;
        take_msg(3, dt_of(3), "R10 one message");
        no_msg("R10 no second message");
        pend_chk("R10 pending ends set");

        // R11 ordering, hold and overflow deferral
        evt(0); evt(1); evt(2); evt(4); evt(7);
        pend_exp[7] = 1'b1;
        repeat (3) @(negedge clk);
        chk(msg_addr, {hi_of(0), lo_of(0)}, "R11 head held");
        take_msg(0, dt_of(0), "R11 order 0");
        take_msg(1, dt_of(1), "R11 order 1");
        take_msg(2, dt_of(2), "R11 order 2");
        take_msg(4, dt_of(4), "R11 order 3");
        no_msg("R11 overflowed event not queued");
        pend_chk("R11 overflow deferred to pending");

        // R12 out-of-range event
        evt(NV);
        no_msg("R12 enabled out-of-range event");
        fn_enable = 0;
        evt(NV + 5);
        pend_chk("R12 pending unchanged");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule